// File: doc/BRIEF.md
# Lockable Watchdog Timer with Early-Warning Interrupt

This block is a register-mapped watchdog. A down-counter steps once per slow tick (a clock enable that marks a 32768 Hz time base, so a timeout of S seconds is loaded as S × 32768 counts). Software programs two 32-bit values, each written as two 16-bit halves: a reset timeout, which sets where the count starts, and a warning threshold. When the count steps down onto the threshold the block latches an interrupt flag. When it steps down onto zero with reset enabled it latches a reset request for the system reset logic.

Every register write except one to the key register is refused while the block is locked, and it leaves reset locked. New load values are not applied at once. A busy flag rises on any load write and stays up for a fixed number of slow ticks. On the last of those ticks the counter and the threshold take the new values together.

Top module: `guard_timer`

## Requirements
- R1: After reset the block is locked (key register reads 1 at bit 0), control, count and status all read 0, and irq and rstReq are low.
- R2: Writing 0x0000E551 to the key register at offset 0x20 unlocks the block, and it then reads 0. Writing any other value locks it. Write access applies only to 32-bit words.
- R3: While locked, writes to every offset except 0x20 have no effect. This includes control (0x08), load halves, mask and status clear.
- R4: Each load value is split into halves. The timeout is held at 0x00 (bits 15:0) and 0x04 (bits 31:16), and the threshold at 0x2C (low) and 0x30 (high). Only wdata bits 15:0 are stored, and reads return the upper 16 bits as 0.
- R5: The status register at 0x10 reports load-busy at bit 4. It is 1 from the cycle after any load-half write until the 2nd tickEn pulse. On that pulse the count takes the new timeout.
- R6: With control bit 1 (count enable) set, the count drops by exactly 1 on each tickEn pulse and stops at 0. With bit 1 clear, or with no tickEn, it holds.
- R7: Status bit 0 sets when a decrement lands the count on the threshold. It stays set until a write to 0x0C with bit 0 set. A count loaded equal to the threshold does not set it.
- R8: irq equals status bit 0 AND control bit 0 (interrupt enable) AND NOT bit 0 of the mask register at 0x14.
- R9: When a decrement lands the count on 0 with control bit 3 (reset enable) set, status bit 3 and rstReq go high. They stay high until a write to 0x0C with bit 3 set. With bit 3 clear, no reset request is raised.
- R10: Reads of 0x18 and 0x1C return bits 15:0 and 31:16 of the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulse per slow tick |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one cycle per write |
| re | input | 1 | Read strobe; rdata is 0 when low |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Gated early-warning interrupt |
| rstReq | output | 1 | Sticky reset request |

## Verification
The assertions assume that tickEn is a one-cycle pulse at most once per clock, and that we and re are never raised at unmapped offsets in a way that expects side effects. The bench holds each strobe for exactly one clock and separates tickEn pulses by an idle cycle. Count checks are taken only once the count is frozen, with control cleared before the readback, so that no tick falls between reading the low half and the high half.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_LDLO  = 6'h00;
  localparam logic [ADDR_W-1:0] A_LDHI  = 6'h04;
  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h08;
  localparam logic [ADDR_W-1:0] A_ICLR  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_RAW   = 6'h10;
  localparam logic [ADDR_W-1:0] A_MASK  = 6'h14;
  localparam logic [ADDR_W-1:0] A_CNTLO = 6'h18;
  localparam logic [ADDR_W-1:0] A_CNTHI = 6'h1C;
  localparam logic [ADDR_W-1:0] A_LOCK  = 6'h20;
  localparam logic [ADDR_W-1:0] A_PRLO  = 6'h2C;
  localparam logic [ADDR_W-1:0] A_PRHI  = 6'h30;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_E551;

  typedef struct packed {
    logic loadWr;
    logic intClr;
    logic rstClr;
  } strobes_t;
endpackage

// File: rtl/guard_timer_ctrl.sv
module guard_timer_ctrl
  import guard_timer_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              we,
  input  logic              re,
  input  logic [CNT_W-1:0]  count,
  input  logic              busy,
  input  logic              intRaw,
  input  logic              rstRaw,
  output strobes_t          stb,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  preVal,
  output logic [3:0]        ctrlWord,
  output logic              locked,
  output logic [31:0]       rdata,
  output logic              irq
);
  logic [HALF_W-1:0] ldLo, ldHi, prLo, prHi;
  logic maskBit;
  logic wrOk;

  assign wrOk = we && !locked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldLo <= '0; ldHi <= '0; prLo <= '0; prHi <= '0;
      ctrlWord <= '0;
      maskBit <= 1'b0;
      locked <= 1'b1;
    end else if (we && addr == A_LOCK) begin
      locked <= (wdata != UNLOCK_KEY);
    end else if (wrOk) begin
      case (addr)
        A_LDLO: ldLo <= wdata[HALF_W-1:0];
        A_LDHI: ldHi <= wdata[HALF_W-1:0];
        A_PRLO: prLo <= wdata[HALF_W-1:0];
        A_PRHI: prHi <= wdata[HALF_W-1:0];
        A_CTRL: ctrlWord <= wdata[3:0];
        A_MASK: maskBit <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    stb.loadWr = wrOk && (addr == A_LDLO || addr == A_LDHI ||
                          addr == A_PRLO || addr == A_PRHI);
    stb.intClr = wrOk && addr == A_ICLR && wdata[0];
    stb.rstClr = wrOk && addr == A_ICLR && wdata[3];
  end

  assign loadVal = {ldHi, ldLo};
  assign preVal  = {prHi, prLo};
  assign irq     = intRaw & ctrlWord[0] & ~maskBit;

  always_comb begin
    rdata = '0;
    if (re) begin
      case (addr)
        A_LDLO:  rdata[HALF_W-1:0] = ldLo;
        A_LDHI:  rdata[HALF_W-1:0] = ldHi;
        A_PRLO:  rdata[HALF_W-1:0] = prLo;
        A_PRHI:  rdata[HALF_W-1:0] = prHi;
        A_CTRL:  rdata[3:0] = ctrlWord;
        A_MASK:  rdata[0] = maskBit;
        A_RAW: begin
          rdata[0] = intRaw;
          rdata[3] = rstRaw;
          rdata[4] = busy;
        end
        A_CNTLO: rdata[HALF_W-1:0] = count[HALF_W-1:0];
        A_CNTHI: rdata[HALF_W-1:0] = count[CNT_W-1:HALF_W];
        A_LOCK:  rdata[0] = locked;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/guard_timer_dp.sv
module guard_timer_dp
  import guard_timer_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int LOAD_TICKS = 2,
  localparam int CNT_W = 2 * HALF_W,
  localparam int TW = (LOAD_TICKS > 1) ? $clog2(LOAD_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  strobes_t         stb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] preVal,
  input  logic             cntEn,
  input  logic             rstEn,
  output logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             intRaw,
  output logic             rstRaw
);
  localparam logic [TW-1:0] T_LAST = TW'(LOAD_TICKS - 1);

  logic [TW-1:0]    tcnt;
  logic [CNT_W-1:0] preThr;
  logic [CNT_W-1:0] nextCnt;
  logic applyNow, stepNow;

  assign applyNow = busy && tickEn && !stb.loadWr && tcnt == T_LAST;
  assign stepNow  = !applyNow && cntEn && tickEn && count != '0;
  assign nextCnt  = count - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      tcnt <= '0;
    end else if (stb.loadWr) begin
      busy <= 1'b1;
      tcnt <= '0;
    end else if (applyNow) begin
      busy <= 1'b0;
    end else if (busy && tickEn) begin
      tcnt <= tcnt + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      preThr <= '0;
    end else if (applyNow) begin
      count  <= loadVal;
      preThr <= preVal;
    end else if (stepNow) begin
      count <= nextCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intRaw <= 1'b0;
      rstRaw <= 1'b0;
    end else begin
      if (stepNow && nextCnt == preThr) intRaw <= 1'b1;
      else if (stb.intClr)              intRaw <= 1'b0;
      if (stepNow && nextCnt == '0 && rstEn) rstRaw <= 1'b1;
      else if (stb.rstClr)                   rstRaw <= 1'b0;
    end
  end
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int LOAD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              we,
  input  logic              re,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              rstReq
);
  localparam int CNT_W = 2 * HALF_W;

  strobes_t         stb;
  logic [CNT_W-1:0] count, loadVal, preVal;
  logic [3:0]       ctrlWord;
  logic             busy, intRaw, rstRaw, locked;

  guard_timer_ctrl #(.HALF_W(HALF_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .count(count), .busy(busy), .intRaw(intRaw), .rstRaw(rstRaw),
    .stb(stb), .loadVal(loadVal), .preVal(preVal), .ctrlWord(ctrlWord),
    .locked(locked), .rdata(rdata), .irq(irq)
  );

  guard_timer_dp #(.HALF_W(HALF_W), .LOAD_TICKS(LOAD_TICKS)) uDp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .stb(stb),
    .loadVal(loadVal), .preVal(preVal),
    .cntEn(ctrlWord[1]), .rstEn(ctrlWord[3]),
    .count(count), .busy(busy), .intRaw(intRaw), .rstRaw(rstRaw)
  );

  assign rstReq = rstRaw;
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
  import guard_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  count,
  input logic              busy,
  input logic              cntEn,
  input logic              intRaw,
  input logic              intClr,
  input logic              rstReq,
  input logic              rstClr,
  input logic              locked,
  input logic [3:0]        ctrlWord,
  input logic              irq
);
  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(count));
  // R6
  step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && cntEn && !busy && count != '0) |=> count == $past(count) - CNT_W'(1));
  // R5
  busy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(tickEn));
  // R7
  int_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intRaw && !intClr) |=> intRaw);
  // R9
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq && !rstClr) |=> rstReq);
  // R9
  rst_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> count == '0);
  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !(we && addr == A_LOCK)) |=> $stable(ctrlWord));
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intRaw);
endmodule

bind guard_timer guard_timer_chk #(.CNT_W(2 * HALF_W)) uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .we(we), .addr(addr),
  .count(count), .busy(busy), .cntEn(ctrlWord[1]), .intRaw(intRaw),
  .intClr(stb.intClr), .rstReq(rstReq), .rstClr(stb.rstClr),
  .locked(locked), .ctrlWord(ctrlWord), .irq(irq)
);

// File: tb/sim_guard_timer.sv
`timescale 1ns/1ps
module sim_guard_timer;
  import guard_timer_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic irq, rstReq;
  int nChk = 0, nFail = 0;
  logic [31:0] v, hi;

  always #2.5 clk = ~clk;

  guard_timer u0 (.clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr),
    .wdata(wdata), .we(we), .re(re), .rdata(rdata), .irq(irq), .rstReq(rstReq));

  // columns: timeout, threshold, ticks, expected count, expected bit0, expected bit3
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV][6] = '{
    '{32'd40,        32'd10,        32'd20, 32'd20,        32'd0, 32'd0},
    '{32'd40,        32'd25,        32'd20, 32'd20,        32'd1, 32'd0},
    '{32'd12,        32'd4,         32'd15, 32'd0,         32'd1, 32'd1},
    '{32'h0001_0005, 32'h0001_0000, 32'd6,  32'h0000_FFFF, 32'd1, 32'd0},
    '{32'd30,        32'd30,        32'd5,  32'd25,        32'd0, 32'd0},
    '{32'd3,         32'd0,         32'd3,  32'd0,         32'd1, 32'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata; re = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic rdCount(output logic [31:0] c);
    logic [31:0] lo, h;
    rd(A_CNTLO, lo); rd(A_CNTHI, h);
    c = {h[15:0], lo[15:0]};
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] p);
    wr(A_LDLO, t & 32'hFFFF); wr(A_LDHI, t >> 16);
    wr(A_PRLO, p & 32'hFFFF); wr(A_PRHI, p >> 16);
  endtask

  initial begin
    #900000;
    nFail++; nChk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(A_LOCK, v); chk("R1 locked", v, 32'd1);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'd0);
    rdCount(v);    chk("R1 count", v, 32'd0);
    rd(A_RAW, v);  chk("R1 status", v, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rstReq", {31'd0, rstReq}, 32'd0);

    // R3 locked writes ignored; R2 wrong key keeps lock
    wr(A_CTRL, 32'hF); wr(A_LDLO, 32'h1234); wr(A_MASK, 32'h1);
    rd(A_CTRL, v); chk("R3 ctrl locked", v, 32'd0);
    rd(A_LDLO, v); chk("R3 load locked", v, 32'd0);
    rd(A_MASK, v); chk("R3 mask locked", v, 32'd0);
    rd(A_RAW, v);  chk("R3 no busy", v, 32'd0);
    wr(A_LOCK, 32'h0001_E551);
    rd(A_LOCK, v); chk("R2 bad key", v, 32'd1);
    wr(A_LOCK, 32'h0000_E551);
    rd(A_LOCK, v); chk("R2 unlock", v, 32'd0);

    // R4 halves
    wr(A_LDHI, 32'hABCD_0002);
    rd(A_LDHI, v); chk("R4 high half", v, 32'h0000_0002);
    wr(A_PRHI, 32'hFFFF_0001);
    rd(A_PRHI, v); chk("R4 pre high", v, 32'h0000_0001);

    // R5 busy and delayed apply
    load(32'h0002_0003, 32'h0000_0005);
    rd(A_RAW, v); chk("R5 busy set", v & 32'h10, 32'h10);
    tick(1);
    rd(A_RAW, v); chk("R5 busy after 1 tick", v & 32'h10, 32'h10);
    rdCount(v);   chk("R5 count before apply", v, 32'd0);
    tick(1);
    rd(A_RAW, v); chk("R5 busy clear", v & 32'h10, 32'h0);
    rdCount(v);   chk("R10 count after apply", v, 32'h0002_0003);

    // R6 freeze with count enable clear
    tick(3);
    rdCount(v); chk("R6 frozen", v, 32'h0002_0003);

    // table walk: R6 R7 R9 R10
    for (int k = 0; k < NV; k++) begin
      wr(A_CTRL, 32'h0);
      load(VEC[k][0], VEC[k][1]);
      tick(2);
      wr(A_ICLR, 32'h9);
      wr(A_CTRL, 32'hB);
      tick(int'(VEC[k][2]));
      wr(A_CTRL, 32'h0);
      rdCount(v);   chk($sformatf("R6 R10 vec%0d count", k), v, VEC[k][3]);
      rd(A_RAW, v);
      chk($sformatf("R7 vec%0d status bit0", k), {31'd0, v[0]}, VEC[k][4]);
      chk($sformatf("R9 vec%0d status bit3", k), {31'd0, v[3]}, VEC[k][5]);
      chk($sformatf("R9 vec%0d rstReq", k), {31'd0, rstReq}, VEC[k][5]);
    end

    // R9 clear of reset request
    wr(A_ICLR, 32'h8);
    chk("R9 rstReq cleared", {31'd0, rstReq}, 32'd0);

    // R8 irq gating, R7 clear
    load(32'd10, 32'd8);
    tick(2);
    wr(A_ICLR, 32'h9);
    wr(A_CTRL, 32'hB);
    tick(2);
    chk("R8 irq on", {31'd0, irq}, 32'd1);
    wr(A_MASK, 32'h1);
    chk("R8 irq masked", {31'd0, irq}, 32'd0);
    wr(A_MASK, 32'h0);
    chk("R8 irq unmasked", {31'd0, irq}, 32'd1);
    wr(A_CTRL, 32'hA);
    chk("R8 irq int-enable off", {31'd0, irq}, 32'd0);
    tick(3);
    rd(A_RAW, v); chk("R7 flag sticky", {31'd0, v[0]}, 32'd1);
    wr(A_ICLR, 32'h1);
    rd(A_RAW, v); chk("R7 flag cleared", {31'd0, v[0]}, 32'd0);

    // R9 no reset request with reset enable clear
    wr(A_CTRL, 32'h0);
    load(32'd3, 32'd7);
    tick(2);
    wr(A_CTRL, 32'h2);
    tick(4);
    rdCount(v);   chk("R9 reached zero", v, 32'd0);
    rd(A_RAW, v); chk("R9 no reset status", {31'd0, v[3]}, 32'd0);
    chk("R9 no rstReq", {31'd0, rstReq}, 32'd0);

    // R2 relock, R3 refusal
    wr(A_LOCK, 32'h0);
    rd(A_LOCK, v); chk("R2 relocked", v, 32'd1);
    wr(A_CTRL, 32'hF);
    rd(A_CTRL, v); chk("R3 ctrl after relock", v, 32'h2);
    hi = 32'd0;
    wr(A_LDLO, 32'h55);
    rd(A_RAW, v); chk("R3 load refused no busy", v & 32'h10, hi);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule